// File: doc/BRIEF.md
# CRC-4 Command Frame Builder

This block prepares the command words that a reader sends to a small-memory contactless card, and it checks the 4-bit CRC of the card's 12-bit answer to a read. The caller gives a card-type code, a read or write selection, an address, a data byte and, for reads, the received response. The block then derives the address width from the card type and forms the command word `(address << 1) | rw`. A bit-serial CRC engine runs over the command bits followed by the data byte, one bit per clock. When that pass ends, the block presents the finished frame and its length in bits.

For a write, the frame is the command, then the data byte, then the CRC. For a read, the frame is the command alone, and the CRC computed over the command and the received data byte is compared with the received CRC nibble. An unrecognised card type produces no frame and raises a flag.

Top module: `cfb_cmd_frame`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_word`, `cmd_len`, `crc_ok` and `type_bad` are all 0.
- R2: The card type sets the address width: 0x0D gives 5 bits, 0x1D gives 8 bits and 0x3D gives 10 bits. With address width `aw`, a read frame is `aw+1` bits long and a write frame is `aw+13` bits long, reported on `cmd_len`.
- R3: A read frame is `cmd_word = (addr << 1) | 1`, with every bit above position `aw` at zero.
- R4: A write frame has 0 in bit 0, the address in bits `aw:1`, the data byte in bits `aw+8:aw+1` and the CRC in bits `aw+12:aw+9`.
- R5: The CRC starts at 0x5 and processes the value `(byte << (aw+1)) | cmd` over `aw+9` bits, starting with bit 0. For each input bit b, it computes `f = crc[3] ^ b`, shifts `crc` left by one with 0 entering bit 0, and XORs in 0xC when `f` is 1. No final XOR is applied.
- R6: For a read, `crc_ok` is 1 exactly when `resp[11:8]` equals the R5 CRC taken over the command and `resp[7:0]`. For a write, `crc_ok` is 0.
- R7: For a start with any other card type, `done` pulses one cycle after the start and `busy` stays low. `type_bad` becomes 1, and `cmd_word`, `cmd_len` and `crc_ok` become 0.
- R8: For a valid type, `busy` rises the cycle after `start` and stays high for `aw+9` cycles. `done` pulses for one cycle in the cycle that follows the last busy cycle, and `type_bad` clears at the start.
- R9: A `start` while `busy` is ignored. The outputs hold their values from one completion to the next.
- R10: Address bits at or above position `aw` have no effect on the frame or on the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| rd_sel | input | 1 | 1 = read command, 0 = write command |
| card_type | input | 8 | Card type code that sets the address width |
| addr | input | 10 | Byte address; only the low `aw` bits are used |
| wr_data | input | 8 | Data byte for a write |
| resp | input | 12 | Read response: CRC in 11:8, data in 7:0 |
| busy | output | 1 | CRC engine shifting |
| done | output | 1 | One-cycle completion pulse |
| cmd_word | output | 23 | Assembled frame, LSB transmitted first |
| cmd_len | output | 5 | Frame length in bits |
| crc_ok | output | 1 | Read response CRC matched |
| type_bad | output | 1 | Last start had an unknown card type |

## Verification
The bench builds the block with its default parameters: a 10-bit address field, an 8-bit data byte and a 4-bit CRC with polynomial 0xC and initial value 0x5. These widths give the longest frame of 23 bits and a 19-bit CRC pass, so all three card widths are exercised. So are the mask on high address bits, the full range of data bytes, and both good and corrupted response nibbles. The bench's behavioural model tracks the latency of every operation, which brings into reach start pulses during a shift, back-to-back operations and unknown type codes.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } cfb_state_e;

endpackage

// File: rtl/cfb_type_decode.sv
module cfb_type_decode #(
   parameter int TYPE_W     = 8,
   parameter int ADDR_MAX_W = 10,
   parameter int AW_W       = 4,
   parameter logic [TYPE_W-1:0] TYPE_S = 8'h0D,
   parameter logic [TYPE_W-1:0] TYPE_M = 8'h1D,
   parameter logic [TYPE_W-1:0] TYPE_L = 8'h3D,
   parameter int AW_S = 5,
   parameter int AW_M = 8,
   parameter int AW_L = 10
) (
   input  logic [TYPE_W-1:0] card_type,
   output logic [AW_W-1:0]   aw,
   output logic              type_ok
);

   // elaboration-time parameter checks
   if (AW_S < 1 || AW_M < 1 || AW_L < 1)
      $error("cfb_type_decode: address widths must be positive");
   if (AW_S > ADDR_MAX_W || AW_M > ADDR_MAX_W || AW_L > ADDR_MAX_W)
      $error("cfb_type_decode: address width exceeds ADDR_MAX_W");
   if ((1 << AW_W) <= ADDR_MAX_W)
      $error("cfb_type_decode: AW_W too narrow");

   always_comb begin
      aw      = '0;
      type_ok = 1'b0;
      if (card_type == TYPE_S) begin
         aw      = AW_W'(AW_S);
         type_ok = 1'b1;
      end else if (card_type == TYPE_M) begin
         aw      = AW_W'(AW_M);
         type_ok = 1'b1;
      end else if (card_type == TYPE_L) begin
         aw      = AW_W'(AW_L);
         type_ok = 1'b1;
      end
   end

endmodule

// File: rtl/cfb_crc_serial.sv
module cfb_crc_serial #(
   parameter int               CRC_W = 4,
   parameter logic [CRC_W-1:0] POLY  = 4'hC,
   parameter logic [CRC_W-1:0] INIT  = 4'h5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             bit_in,
   output logic [CRC_W-1:0] crc_q,
   output logic [CRC_W-1:0] crc_nx
);

   if (CRC_W < 2)
      $error("cfb_crc_serial: CRC_W must be at least 2");

   logic fb;
   assign fb = crc_q[CRC_W-1] ^ bit_in;

   // one register stage per CRC bit, polynomial taps selected per bit
   for (genvar i = 0; i < CRC_W; i++) begin : g_tap
      if (i == 0) begin : g_low
         assign crc_nx[i] = fb & POLY[i];
      end else begin : g_high
         assign crc_nx[i] = crc_q[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= INIT;
      else if (clear)
         crc_q <= INIT;
      else if (en)
         crc_q <= crc_nx;
   end

endmodule

// File: rtl/cfb_frame_pack.sv
module cfb_frame_pack #(
   parameter int CMD_MAX = 11,
   parameter int DATA_W  = 8,
   parameter int CRC_W   = 4,
   parameter int AW_W    = 4,
   parameter int FRAME_W = CMD_MAX + DATA_W + CRC_W,
   parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
   input  logic               rd,
   input  logic [AW_W-1:0]    aw,
   input  logic [CMD_MAX-1:0] cmd,
   input  logic [DATA_W-1:0]  data,
   input  logic [CRC_W-1:0]   crc,
   output logic [FRAME_W-1:0] word,
   output logic [LEN_W-1:0]   len
);

   logic [LEN_W-1:0] data_pos;
   logic [LEN_W-1:0] crc_pos;

   assign data_pos = LEN_W'(aw) + LEN_W'(1);
   assign crc_pos  = data_pos + LEN_W'(DATA_W);

   always_comb begin
      if (rd) begin
         word = FRAME_W'(cmd);
         len  = data_pos;
      end else begin
         word = FRAME_W'(cmd)
              | (FRAME_W'(data) << data_pos)
              | (FRAME_W'(crc)  << crc_pos);
         len  = crc_pos + LEN_W'(CRC_W);
      end
   end

endmodule

// File: rtl/cfb_cmd_frame.sv
module cfb_cmd_frame
   import cfb_pkg::*;
#(
   parameter int TYPE_W     = 8,
   parameter int ADDR_MAX_W = 10,
   parameter int DATA_W     = 8,
   parameter int CRC_W      = 4,
   parameter logic [CRC_W-1:0] CRC_POLY = 4'hC,
   parameter logic [CRC_W-1:0] CRC_INIT = 4'h5,
   parameter int RESP_W     = DATA_W + CRC_W,
   parameter int FRAME_W    = ADDR_MAX_W + 1 + DATA_W + CRC_W,
   parameter int LEN_W      = $clog2(FRAME_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  rd_sel,
   input  logic [TYPE_W-1:0]     card_type,
   input  logic [ADDR_MAX_W-1:0] addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [RESP_W-1:0]     resp,
   output logic                  busy,
   output logic                  done,
   output logic [FRAME_W-1:0]    cmd_word,
   output logic [LEN_W-1:0]      cmd_len,
   output logic                  crc_ok,
   output logic                  type_bad
);

   localparam int CMD_MAX = ADDR_MAX_W + 1;
   localparam int SH_W    = CMD_MAX + DATA_W;
   localparam int CNT_W   = $clog2(SH_W + 1);
   localparam int AW_W    = $clog2(ADDR_MAX_W + 1);

   if (RESP_W != DATA_W + CRC_W)
      $error("cfb_cmd_frame: RESP_W must equal DATA_W + CRC_W");
   if (FRAME_W != CMD_MAX + DATA_W + CRC_W)
      $error("cfb_cmd_frame: FRAME_W inconsistent with field widths");

   cfb_state_e             state_q;
   logic [AW_W-1:0]        aw_c, aw_q;
   logic                   type_ok;
   logic [ADDR_MAX_W-1:0]  addr_m;
   logic [CMD_MAX-1:0]     cmd_c, cmd_q;
   logic [DATA_W-1:0]      byte_c, byte_q;
   logic [CRC_W-1:0]       rcrc_q;
   logic                   rd_q;
   logic [SH_W-1:0]        sh_q;
   logic [CNT_W-1:0]       cnt_q, cnt_init;
   logic [CRC_W-1:0]       crc_q, crc_nx;
   logic                   accept;
   logic [FRAME_W-1:0]     pack_word;
   logic [LEN_W-1:0]       pack_len;

   cfb_type_decode #(
      .TYPE_W(TYPE_W), .ADDR_MAX_W(ADDR_MAX_W), .AW_W(AW_W)
   ) u_dec (
      .card_type(card_type), .aw(aw_c), .type_ok(type_ok)
   );

   // keep only the low aw address bits
   assign addr_m   = addr & ~({ADDR_MAX_W{1'b1}} << aw_c);
   assign cmd_c    = {addr_m, rd_sel};
   assign byte_c   = rd_sel ? resp[DATA_W-1:0] : wr_data;
   assign cnt_init = CNT_W'(aw_c) + CNT_W'(1) + CNT_W'(DATA_W);
   assign accept   = (state_q == ST_IDLE) && start && type_ok;

   cfb_crc_serial #(
      .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
   ) u_crc (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .en(state_q == ST_SHIFT), .bit_in(sh_q[0]),
      .crc_q(crc_q), .crc_nx(crc_nx)
   );

   cfb_frame_pack #(
      .CMD_MAX(CMD_MAX), .DATA_W(DATA_W), .CRC_W(CRC_W),
      .AW_W(AW_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
   ) u_pack (
      .rd(rd_q), .aw(aw_q), .cmd(cmd_q), .data(byte_q),
      .crc(crc_nx), .word(pack_word), .len(pack_len)
   );

   assign busy = (state_q == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         aw_q     <= '0;
         cmd_q    <= '0;
         byte_q   <= '0;
         rcrc_q   <= '0;
         rd_q     <= 1'b0;
         sh_q     <= '0;
         cnt_q    <= '0;
         done     <= 1'b0;
         cmd_word <= '0;
         cmd_len  <= '0;
         crc_ok   <= 1'b0;
         type_bad <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start && !type_ok) begin
                  done     <= 1'b1;
                  type_bad <= 1'b1;
                  cmd_word <= '0;
                  cmd_len  <= '0;
                  crc_ok   <= 1'b0;
               end else if (accept) begin
                  type_bad <= 1'b0;
                  state_q  <= ST_SHIFT;
                  aw_q     <= aw_c;
                  cmd_q    <= cmd_c;
                  byte_q   <= wr_data;
                  rcrc_q   <= resp[RESP_W-1:DATA_W];
                  rd_q     <= rd_sel;
                  sh_q     <= SH_W'(cmd_c) | (SH_W'(byte_c) << (CNT_W'(aw_c) + CNT_W'(1)));
                  cnt_q    <= cnt_init;
               end
            end
            ST_SHIFT: begin
               sh_q  <= sh_q >> 1;
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1)) begin
                  state_q  <= ST_IDLE;
                  done     <= 1'b1;
                  cmd_word <= pack_word;
                  cmd_len  <= pack_len;
                  crc_ok   <= rd_q && (crc_nx == rcrc_q);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfb_cmd_frame_chk.sv
module cfb_cmd_frame_chk #(
   parameter int FRAME_W = 23,
   parameter int LEN_W   = 5,
   parameter int CMD_MAX = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [FRAME_W-1:0] cmd_word,
   input logic [LEN_W-1:0]   cmd_len,
   input logic               crc_ok,
   input logic               type_bad
);

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R8

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R8

   AST_BAD_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      type_bad |-> (cmd_len == '0 && cmd_word == '0)); // R7

   AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cmd_word[0]) |-> (cmd_len <= LEN_W'(CMD_MAX))); // R3

   AST_WRITE_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cmd_word[0] && cmd_len != '0) |-> !crc_ok); // R6

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cmd_word) && $stable(cmd_len))); // R9

endmodule

bind cfb_cmd_frame cfb_cmd_frame_chk #(
   .FRAME_W(FRAME_W), .LEN_W(LEN_W), .CMD_MAX(ADDR_MAX_W + 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .cmd_word(cmd_word), .cmd_len(cmd_len), .crc_ok(crc_ok), .type_bad(type_bad)
);

// File: tb/cfb_cmd_frame_tb.sv
`timescale 1ns/1ps
module cfb_cmd_frame_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_sel = 1'b0;
   logic [7:0]  card_type = '0;
   logic [9:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [11:0] resp = '0;
   logic        busy, done, crc_ok, type_bad;
   logic [22:0] cmd_word;
   logic [4:0]  cmd_len;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   cfb_cmd_frame u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
      .card_type(card_type), .addr(addr), .wr_data(wr_data), .resp(resp),
      .busy(busy), .done(done), .cmd_word(cmd_word), .cmd_len(cmd_len),
      .crc_ok(crc_ok), .type_bad(type_bad)
   );

   function automatic int aw_of(int t);
      case (t)
         8'h0D: return 5;
         8'h1D: return 8;
         8'h3D: return 10;
         default: return 0;
      endcase
   endfunction

   // R5: CRC as stated in the requirement
   function automatic int crc_of(longint cmdv, int cl, longint dv);
      int s = 5;
      longint v = (dv << cl) | cmdv;
      for (int i = 0; i < cl + 8; i++) begin
         int b  = int'((v >> i) & 1);
         int fb = ((s >> 3) & 1) ^ b;
         s = (s << 1) & 15;
         if (fb != 0) s = s ^ 12;
      end
      return s;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // behavioural reference model
   int     m_cnt;
   bit     m_done, m_ok, m_bad, m_rd;
   longint m_word, p_word;
   int     m_len, p_len;
   bit     p_ok;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_done <= 0; m_ok <= 0; m_bad <= 0;
         m_word <= 0; m_len <= 0; m_rd <= 0;
      end else begin
         m_done <= 0;
         if (m_cnt > 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
               m_done <= 1; m_word <= p_word; m_len <= p_len; m_ok <= p_ok;
            end
         end else if (start) begin
            int aw;
            aw = aw_of(int'(card_type));
            if (aw == 0) begin
               m_done <= 1; m_bad <= 1; m_word <= 0; m_len <= 0; m_ok <= 0;
            end else begin
               longint cmdv, dv;
               int c;
               cmdv = ((longint'(addr) & ((64'd1 << aw) - 1)) << 1) | longint'(rd_sel);
               m_bad <= 0;
               m_cnt <= aw + 9;
               m_rd  <= rd_sel;
               if (rd_sel) begin
                  dv = longint'(resp[7:0]);
                  c  = crc_of(cmdv, aw + 1, dv);
                  p_word = cmdv;
                  p_len  = aw + 1;
                  p_ok   = (c == int'(resp[11:8]));
               end else begin
                  dv = longint'(wr_data);
                  c  = crc_of(cmdv, aw + 1, dv);
                  p_word = cmdv | (dv << (aw + 1)) | (longint'(c) << (aw + 9));
                  p_len  = aw + 13;
                  p_ok   = 0;
               end
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R8 busy", longint'(busy), longint'(m_cnt > 0));
         chk("R8 done", longint'(done), longint'(m_done));
         chk("R7 type_bad", longint'(type_bad), longint'(m_bad));
         chk(m_rd ? "R3 R10 read word" : "R4 R5 R10 write word", longint'(cmd_word), m_word);
         chk("R2 cmd_len", longint'(cmd_len), longint'(m_len));
         chk("R6 crc_ok", longint'(crc_ok), longint'(m_ok));
      end
   end

   task automatic op(int t, bit rd, int a, int d, int r);
      @(negedge clk);
      card_type = 8'(t); rd_sel = rd; addr = 10'(a); wr_data = 8'(d); resp = 12'(r);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_cnt != 0) @(negedge clk);
   endtask

   function automatic int good_resp(int t, int a, int d);
      int aw = aw_of(t);
      longint cmdv = ((longint'(a) & ((64'd1 << aw) - 1)) << 1) | 1;
      return (crc_of(cmdv, aw + 1, longint'(d)) << 8) | (d & 255);
   endfunction

   initial begin
      int types[3] = '{8'h0D, 8'h1D, 8'h3D};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset", longint'({busy, done, cmd_word, cmd_len, crc_ok, type_bad}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", longint'({busy, done, cmd_word, cmd_len, crc_ok, type_bad}), 0);

      foreach (types[k]) begin
         // R3 R6: reads with correct and corrupted CRC nibbles
         op(types[k], 1, 3, 8'h5A, good_resp(types[k], 3, 8'h5A));
         chk("R6 good read", longint'(crc_ok), 1);
         op(types[k], 1, 17, 8'hC3, good_resp(types[k], 17, 8'hC3) ^ 12'h100);
         chk("R6 bad read", longint'(crc_ok), 0);
         // R10: high address bits above aw must not matter
         op(types[k], 1, 10'h3FF, 8'h00, good_resp(types[k], 10'h3FF, 8'h00));
         chk("R10 masked read ok", longint'(crc_ok), 1);
         // R4 R5: writes with several data patterns
         op(types[k], 0, 5, 8'h00, 0);
         op(types[k], 0, 10'h3FF, 8'hFF, 0);
         op(types[k], 0, 10'h2AA, 8'hA5, 12'hFFF);
         chk("R2 write len", longint'(cmd_len), longint'(aw_of(types[k]) + 13));
      end

      // R7: unknown types, back-to-back
      op(8'h00, 0, 1, 1, 0);
      chk("R7 bad flag", longint'(type_bad), 1);
      op(8'h1E, 1, 1, 1, 0);
      op(8'hFF, 0, 1, 1, 0);
      op(8'h1D, 0, 9, 8'h3C, 0);
      chk("R8 flag cleared", longint'(type_bad), 0);

      // R9: start pulses during a shift are ignored
      @(negedge clk);
      card_type = 8'h3D; rd_sel = 0; addr = 10'h155; wr_data = 8'h81; start = 1;
      @(negedge clk);
      card_type = 8'h0D; rd_sel = 1; addr = 10'h0F0; wr_data = 8'h7E;
      repeat (4) @(negedge clk);
      card_type = 8'h00;
      @(negedge clk);
      start = 0;
      while (m_cnt != 0) @(negedge clk);
      repeat (3) @(negedge clk);

      // sweep of addresses and data
      for (int i = 0; i < 24; i++) begin
         int t = types[i % 3];
         op(t, i[0], i * 37, i * 29 + 7, (i[1]) ? good_resp(t, i * 37, i * 29 + 7) : (i * 91));
      end
      repeat (3) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule